// File: doc/BRIEF.md
# Serviced Software Watchdog Timer

This block is a software watchdog built around a 16-bit down-counter. Software must keep proving that it is alive by writing a fixed pair of key values to a service port. Each completed pair reloads the counter from a programmed timeout. If software stops servicing, the counter reaches zero and the block issues a one-cycle timeout request. A routing bit in the configuration sends that request either to the chip reset logic or to a machine-check interrupt input.

A single configuration word sets the timeout count, the run enable, an optional divide-by-2048 prescale and the routing choice. That word can be written once after reset. A new timeout count does not disturb the running counter: it only takes effect at the next completed service pair. After reset the counter starts at 0xFFFF and counts on every system clock, so a system that never programs the block is still protected.

Top module: `wdog_svc_top`

## Requirements
- R1: While reset is asserted, `count_o` is 0xFFFF, `rst_req_o` and `mcp_req_o` are 0, `cfg_locked_o` and `svc_armed_o` are 0. The reset configuration is timeout 0xFFFF, run enabled, prescale off and routing to reset.
- R2: The first `cfg_wr` after reset is accepted and sets `cfg_locked_o`. Its bit layout is: `cfg_wdata[15:0]` timeout count, bit 16 run enable, bit 17 prescale enable, bit 18 routing (1 = reset request, 0 = machine-check request). Enable, prescale and routing act from the next clock.
- R3: Once `cfg_locked_o` is 1, further configuration writes change nothing, neither the run enable nor the routing nor the timeout that a later service loads.
- R4: Accepting a new timeout count leaves the running counter's value and decrement unchanged.
- R5: A service write of 0x556C arms the sequence (`svc_armed_o` = 1), and 0x556C while already armed keeps it armed. A following write of 0xAA39 loads the timeout count into the counter at that clock and disarms. Any other value disarms. A 0xAA39 write while not armed does nothing.
- R6: With run enabled and prescale off, `count_o` falls by one on every clock until it reaches 0.
- R7: With prescale on, the counter falls by one once every 2048 clocks. The prescaler restarts at every reload, so after a reload the first decrement happens on the 2048th clock.
- R8: With run disabled, `count_o` holds its value. A service reload still loads it.
- R9: The clock that takes the counter from 1 to 0 raises a one-cycle pulse on `rst_req_o` when routing is 1, or on `mcp_req_o` when routing is 0, never both. The counter then stays at 0 until it is reloaded.
- R10: When a reload and the 1-to-0 step fall on the same clock, the reload wins: the counter takes the timeout value and no request pulse is issued.
- R11: `expired_o` is 1 exactly when `count_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 19 | Configuration word (layout in R2) |
| svc_wr | input | 1 | Service register write strobe |
| svc_wdata | input | 16 | Service key value |
| rst_req_o | output | 1 | One-cycle timeout request to reset logic |
| mcp_req_o | output | 1 | One-cycle timeout request to machine-check logic |
| count_o | output | 16 | Current counter value |
| expired_o | output | 1 | Counter is at zero |
| cfg_locked_o | output | 1 | Configuration has been written and is frozen |
| svc_armed_o | output | 1 | First service key seen, waiting for the second |

## Verification
The service reload and the expiry step can fall on the same clock, and the result decides whether a late but valid service still rescues the system. The bench waits until the counter shows 2, writes 0x556C, and then writes 0xAA39 so that it lands on the very clock that would take the counter to zero. The judged outcome is the timeout value on `count_o` with neither request output pulsing. A cycle-accurate reference model in the bench also compares every cycle during random service traffic, where such coincidences and disarming writes happen by chance.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int unsigned WD_CNT_W = 16;

  // Packed MSB first: routing at bit 18, prescale at 17, run at 16, timeout 15:0
  typedef struct packed {
    logic                route_rst;
    logic                pre_en;
    logic                run_en;
    logic [WD_CNT_W-1:0] tmo;
  } wd_cfg_t;

  localparam int unsigned WD_CFG_W = $bits(wd_cfg_t);

  function automatic wd_cfg_t f_cfg_default();
    wd_cfg_t c;
    c.route_rst = 1'b1;
    c.pre_en    = 1'b0;
    c.run_en    = 1'b1;
    c.tmo       = '1;
    return c;
  endfunction

  // Step enable for the down-counter
  function automatic logic f_tick(input logic run_en, input logic pre_en,
                                  input logic pre_pulse);
    return run_en && (!pre_en || pre_pulse);
  endfunction

  // Next counter value: reload dominates, zero is sticky
  function automatic logic [WD_CNT_W-1:0] f_next_count(
      input logic [WD_CNT_W-1:0] cur, input logic tick,
      input logic reload, input logic [WD_CNT_W-1:0] tmo);
    if (reload)                 return tmo;
    else if (tick && cur != '0) return cur - 1'b1;
    else                        return cur;
  endfunction

  // Expiry happens on the step from one to zero, unless reloaded
  function automatic logic f_expires(input logic [WD_CNT_W-1:0] cur,
                                     input logic tick, input logic reload);
    return !reload && tick && (cur == {{(WD_CNT_W-1){1'b0}}, 1'b1});
  endfunction

endpackage

// File: rtl/wdog_cfg_reg.sv
module wdog_cfg_reg
  import wdog_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wr,
  input  wd_cfg_t wdata,
  output wd_cfg_t cfg_o,
  output logic    locked_o
);

  wd_cfg_t cfg_q;
  logic    locked_q;
  logic    accept;

  assign accept = wr && !locked_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= f_cfg_default();
      locked_q <= 1'b0;
    end else if (accept) begin
      cfg_q    <= wdata;
      locked_q <= 1'b1;
    end
  end

  assign cfg_o    = cfg_q;
  assign locked_o = locked_q;

  // R3
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> $stable(cfg_q));

  // R2
  cfg_lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> locked_q);

endmodule

// File: rtl/wdog_svc_seq.sv
module wdog_svc_seq #(
  parameter int unsigned KEY_W = 16,
  parameter logic [KEY_W-1:0] KEY_A = 16'h556C,
  parameter logic [KEY_W-1:0] KEY_B = 16'hAA39
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [KEY_W-1:0] wdata,
  output logic             reload_o,
  output logic             armed_o
);

  logic armed_q;
  logic hit_a;
  logic hit_b;

  assign hit_a = wr && (wdata == KEY_A);
  assign hit_b = wr && (wdata == KEY_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  armed_q <= 1'b0;
    else if (wr) armed_q <= hit_a;
  end

  assign reload_o = hit_b && armed_q;
  assign armed_o  = armed_q;

  // R5
  svc_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wdata != KEY_A) |=> !armed_q);

  // R5
  svc_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wdata == KEY_A) |=> armed_q);

  // R5
  svc_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(armed_q));

endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int unsigned PRE_W = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic pulse_o
);

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pre_q <= '0;
    else if (clr) pre_q <= '0;
    else          pre_q <= pre_q + 1'b1;
  end

  assign pulse_o = &pre_q;

  // R7
  pre_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);

  // R7
  pre_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !pulse_o);

endmodule

// File: rtl/wdog_downcnt.sv
module wdog_downcnt
  import wdog_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reload,
  input  logic [WD_CNT_W-1:0] tmo,
  input  logic                tick,
  output logic [WD_CNT_W-1:0] cnt_o,
  output logic                fire_o
);

  logic [WD_CNT_W-1:0] cnt_q;
  logic                fire_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '1;
      fire_q <= 1'b0;
    end else begin
      cnt_q  <= f_next_count(cnt_q, tick, reload, tmo);
      fire_q <= f_expires(cnt_q, tick, reload);
    end
  end

  assign cnt_o  = cnt_q;
  assign fire_o = fire_q;

  // R9
  fire_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |-> cnt_q == '0);

  // R9
  fire_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |=> !fire_q);

  // R5
  reload_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> cnt_q == $past(tmo));

  // R10
  reload_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> !fire_q);

  // R9
  zero_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !reload) |=> cnt_q == '0);

  // R8
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && !tick) |=> $stable(cnt_q));

endmodule

// File: rtl/wdog_svc_top.sv
module wdog_svc_top
  import wdog_pkg::*;
#(
  parameter int unsigned PRE_W = 11,
  parameter logic [WD_CNT_W-1:0] KEY_A = 16'h556C,
  parameter logic [WD_CNT_W-1:0] KEY_B = 16'hAA39
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic [WD_CFG_W-1:0] cfg_wdata,
  input  logic                svc_wr,
  input  logic [WD_CNT_W-1:0] svc_wdata,
  output logic                rst_req_o,
  output logic                mcp_req_o,
  output logic [WD_CNT_W-1:0] count_o,
  output logic                expired_o,
  output logic                cfg_locked_o,
  output logic                svc_armed_o
);

  wd_cfg_t cfg;
  logic    svc_reload;
  logic    pre_pulse;
  logic    step_en;
  logic    fire;

  wdog_cfg_reg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (cfg_wr),
    .wdata    (wd_cfg_t'(cfg_wdata)),
    .cfg_o    (cfg),
    .locked_o (cfg_locked_o)
  );

  wdog_svc_seq #(
    .KEY_W (WD_CNT_W),
    .KEY_A (KEY_A),
    .KEY_B (KEY_B)
  ) u_svc (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (svc_wr),
    .wdata    (svc_wdata),
    .reload_o (svc_reload),
    .armed_o  (svc_armed_o)
  );

  wdog_prescaler #(
    .PRE_W (PRE_W)
  ) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (svc_reload),
    .pulse_o (pre_pulse)
  );

  assign step_en = f_tick(cfg.run_en, cfg.pre_en, pre_pulse);

  wdog_downcnt u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .reload (svc_reload),
    .tmo    (cfg.tmo),
    .tick   (step_en),
    .cnt_o  (count_o),
    .fire_o (fire)
  );

  assign rst_req_o = fire &&  cfg.route_rst;
  assign mcp_req_o = fire && !cfg.route_rst;
  assign expired_o = (count_o == '0);

  // R9
  route_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req_o && mcp_req_o));

  // R8
  run_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.run_en && !svc_reload) |=> $stable(count_o));

  // R6
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.run_en && !cfg.pre_en && !svc_reload && count_o != '0)
      |=> count_o == $past(count_o) - 1'b1);

  // R4
  cfg_no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !svc_reload && !cfg.run_en) |=> $stable(count_o));

endmodule

// File: tb/tb_wdog_svc_top.sv
module tb_wdog_svc_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [18:0] cfg_wdata = '0;
  logic        svc_wr = 1'b0;
  logic [15:0] svc_wdata = '0;
  logic        rst_req_o, mcp_req_o, expired_o, cfg_locked_o, svc_armed_o;
  logic [15:0] count_o;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;
  bit live_cmp = 1'b0;

  always #4 clk = ~clk;

  wdog_svc_top dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .svc_wr(svc_wr), .svc_wdata(svc_wdata), .rst_req_o(rst_req_o),
    .mcp_req_o(mcp_req_o), .count_o(count_o), .expired_o(expired_o),
    .cfg_locked_o(cfg_locked_o), .svc_armed_o(svc_armed_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [18:0] mk_cfg(bit route, bit pre, bit run, logic [15:0] t);
    return {route, pre, run, t};
  endfunction

  // Bench reference model, written from the requirements
  bit          m_lock, m_run, m_pre, m_route, m_arm, m_rst, m_mcp;
  int          m_tmo, m_cnt, m_pc;

  function automatic bit m_step(bit run, bit pre, int pc);
    if (!run) return 0;
    if (!pre) return 1;
    return pc == 2047;
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    bit rl, st;
    if (!rst_n) begin
      m_lock = 0; m_run = 1; m_pre = 0; m_route = 1; m_arm = 0;
      m_rst = 0; m_mcp = 0; m_tmo = 16'hFFFF; m_cnt = 16'hFFFF; m_pc = 0;
    end else begin
      rl = svc_wr && m_arm && svc_wdata == 16'hAA39;
      st = m_step(m_run, m_pre, m_pc);
      m_rst = 0; m_mcp = 0;
      if (rl) m_cnt = m_tmo;
      else if (st && m_cnt > 0) begin
        if (m_cnt == 1) begin
          if (m_route) m_rst = 1; else m_mcp = 1;
        end
        m_cnt = m_cnt - 1;
      end
      m_pc = rl ? 0 : (m_pc + 1) % 2048;
      if (svc_wr) m_arm = (svc_wdata == 16'h556C);
      if (cfg_wr && !m_lock) begin
        m_lock = 1; m_tmo = cfg_wdata[15:0]; m_run = cfg_wdata[16];
        m_pre = cfg_wdata[17]; m_route = cfg_wdata[18];
      end
    end
  end

  // Per-cycle comparison against the model, sampled on the falling edge
  always @(negedge clk) begin
    if (rst_n && live_cmp) begin
      chk(count_o == m_cnt[15:0], "R6/R7/R8 model count", count_o, m_cnt);
      chk(rst_req_o == m_rst, "R9 model rst_req", rst_req_o, m_rst);
      chk(mcp_req_o == m_mcp, "R9 model mcp_req", mcp_req_o, m_mcp);
      chk(svc_armed_o == m_arm, "R5 model armed", svc_armed_o, m_arm);
      chk(expired_o == (count_o == 0), "R11 expired flag", expired_o, count_o == 0);
    end
  end

  task automatic svc_put(input logic [15:0] v);
    svc_wr = 1'b1; svc_wdata = v;
    @(negedge clk);
    svc_wr = 1'b0;
  endtask

  task automatic cfg_put(input logic [18:0] v);
    cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic do_reset();
    live_cmp = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    chk(count_o == 16'hFFFF, "R1 reset count", count_o, 16'hFFFF);
    chk(!rst_req_o && !mcp_req_o, "R1 reset requests", {rst_req_o, mcp_req_o}, 0);
    chk(!cfg_locked_o && !svc_armed_o, "R1 reset lock/arm", {cfg_locked_o, svc_armed_o}, 0);
    rst_n = 1'b1;
    live_cmp = 1;
  endtask

  task automatic wait_count(input int v);
    int guard = 0;
    while (count_o != v && guard < 70000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  initial begin : wdog_timer
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin : main
    int c;
    void'($urandom(32'd20240611));
    @(negedge clk);

    // ---------- Phase A: route to reset, timeout 20 ----------
    do_reset();
    repeat (3) @(negedge clk);
    chk(count_o == 16'hFFFC, "R1 counts from max after reset", count_o, 16'hFFFC);
    cfg_put(mk_cfg(1, 0, 1, 16'd20));
    chk(cfg_locked_o, "R2 first write locks", cfg_locked_o, 1);
    c = count_o;
    @(negedge clk);
    chk(count_o == c - 1, "R4 new timeout leaves counter running", count_o, c - 1);
    chk(count_o > 20, "R4 counter not reloaded", count_o, 21);
    cfg_put(mk_cfg(0, 0, 0, 16'd7));
    c = count_o;
    repeat (2) @(negedge clk);
    chk(count_o == c - 2, "R3 ignored write keeps run enabled", count_o, c - 2);
    svc_put(16'hAA39);
    chk(count_o == c - 3, "R5 lone second key ignored", count_o, c - 3);
    svc_put(16'h556C);
    svc_put(16'h1234);
    svc_put(16'hAA39);
    chk(count_o > 20, "R5 broken sequence no reload", count_o, 21);
    svc_put(16'h556C);
    svc_put(16'h556C);
    chk(svc_armed_o, "R5 repeated first key stays armed", svc_armed_o, 1);
    svc_put(16'hAA39);
    chk(count_o == 20, "R5 R3 reload uses first timeout", count_o, 20);
    // R10: reload lands on the clock that would expire
    wait_count(2);
    svc_put(16'h556C);
    chk(count_o == 1, "R10 setup count one", count_o, 1);
    svc_put(16'hAA39);
    chk(count_o == 20 && !rst_req_o && !mcp_req_o, "R10 reload beats expiry",
        {rst_req_o, mcp_req_o, count_o}, 20);
    wait_count(1);
    chk(!expired_o, "R11 not expired at one", expired_o, 0);
    @(negedge clk);
    chk(count_o == 0 && rst_req_o && !mcp_req_o, "R9 reset pulse at expiry",
        {rst_req_o, mcp_req_o, count_o}, 32'h20000);
    chk(expired_o, "R11 expired at zero", expired_o, 1);
    @(negedge clk);
    chk(!rst_req_o && count_o == 0, "R9 single pulse, zero held", {rst_req_o, count_o}, 0);
    repeat (5) @(negedge clk);
    chk(count_o == 0, "R9 stays at zero", count_o, 0);
    // random service traffic, model compared every cycle
    for (int i = 0; i < 400; i++) begin
      int sel = $urandom % 10;
      if (sel < 4)      svc_put(16'h556C);
      else if (sel < 7) svc_put(16'hAA39);
      else if (sel < 9) svc_put(16'($urandom));
      else              cfg_put(19'($urandom));
      repeat ($urandom % 28) @(negedge clk);
    end

    // ---------- Phase B: prescale, route to machine check ----------
    do_reset();
    cfg_put(mk_cfg(0, 1, 1, 16'd3));
    svc_put(16'h556C);
    svc_put(16'hAA39);
    chk(count_o == 3, "R7 reload with prescale", count_o, 3);
    repeat (2047) @(negedge clk);
    chk(count_o == 3, "R7 no step before 2048 clocks", count_o, 3);
    @(negedge clk);
    chk(count_o == 2, "R7 step on 2048th clock", count_o, 2);
    wait_count(0);
    chk(mcp_req_o && !rst_req_o, "R9 machine-check routing", {rst_req_o, mcp_req_o}, 1);
    @(negedge clk);
    chk(!mcp_req_o, "R9 machine-check single pulse", mcp_req_o, 0);

    // ---------- Phase C: run disabled ----------
    do_reset();
    cfg_put(mk_cfg(1, 0, 0, 16'd5));
    c = count_o;
    repeat (50) @(negedge clk);
    chk(count_o == c, "R8 disabled counter holds", count_o, c);
    svc_put(16'h556C);
    svc_put(16'hAA39);
    chk(count_o == 5, "R8 reload while disabled", count_o, 5);
    repeat (20) @(negedge clk);
    chk(count_o == 5 && !rst_req_o, "R8 reload value holds", count_o, 5);

    live_cmp = 0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule